// File: doc/BRIEF.md
# Read-Only I2C Conversion Result Slave

This block sits beside a 16-bit converter and makes its latest result readable over a two-wire I2C bus. It is only ever a slave. It watches the bus for START, repeated START and STOP conditions and collects the 7-bit address that the master sends. When that address matches the one picked by a strap pin and the master asks to read, the block acknowledges. It then shifts out the result it holds, high byte first, by pulling an open-drain SDA line low or releasing it. It never drives the line high, never stretches SCL and has no registers that a master can write.

The converter side hands over each finished result on a parallel port with a one-cycle valid strobe. The block keeps the newest such value. It copies that value into a transmit shift register at the moment the address is acknowledged. A result that arrives while bytes are on the wire therefore waits for the next read and cannot mix into the transfer in progress. There is no conversion latency on the bus: a read always returns the most recent completed result. Results are offset binary, so the block passes 0x8000 (zero input) and 0x7FF8 (8 LSB below zero) through unchanged.

Both bus lines are brought into the system clock domain through two flip-flops each, and SCL edges are found from the synchronised copy. The system clock must therefore be many times the bus bit rate. At both 100 kbit/s and 400 kbit/s a clock of a few MHz or more leaves a wide margin.

Top module: `adc_result_i2c_slave`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth SCL clock) only when the seven received address bits, sent MSB first, equal 0010100 with `addrSel` low or 1010100 with `addrSel` high, and the eighth bit (R/W) is 1.
- R2: A non-matching address or a write request (R/W = 0) gets no acknowledge, and SDA stays released (a master clocking bytes reads 0xFF) until the next START.
- R3: After an acknowledged read, the result goes out MSB first: the high byte (bits 15..8) and then the low byte. Each new bit appears after an SCL falling edge and is stable while SCL is high. Bit 15 is present from the falling edge that ends the acknowledge clock.
- R4: After the high byte, SDA is released for the master's acknowledge. If the master acknowledges (SDA low), the low byte follows. If it does not (SDA high), SDA stays released.
- R5: After the low byte, SDA stays released (further bytes read 0xFF) until a STOP or repeated START.
- R6: The value sent is the result held when the address is acknowledged. A `resultValid` strobe during a transfer does not change the bytes being sent, and the next read returns that newer result.
- R7: A START or repeated START in any state restarts address reception. A STOP in any state returns the block to idle with SDA released.
- R8: `sdaPullLow` is 0 after reset, and it only starts pulling while the synchronised SCL is low, so the block never creates a START or STOP itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pad |
| sdaIn | input | 1 | Bus data line as seen on the pad |
| sdaPullLow | output | 1 | 1 enables the open-drain pull-down on SDA |
| addrSel | input | 1 | Address strap: 0 selects 0010100, 1 selects 1010100 |
| resultData | input | 16 | Newly completed conversion result |
| resultValid | input | 1 | One-cycle strobe qualifying `resultData` |

## Verification
The bench builds the block with its default parameters: a 16-bit result sent as two bytes, two-flop synchronisers and the two strap addresses. It runs the bus with 20 system clocks per quarter bit, so every SCL edge passes through the synchroniser and edge detector well before the master samples. With both strap addresses and both read and write requests, the acknowledge decision is exercised for both values of the strap. Master NACK after the first byte, reads past the last byte, a repeated START in the middle of the address, and a result update during a transfer reach the release and capture corners.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_WAIT
  } slvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic addrShift;   // sample SDA into the address register
    logic loadResult;  // copy held result into transmit shifter
    logic dataShift;   // advance transmit shifter by one bit
  } dpCmd_t;

endpackage

// File: rtl/adc_i2c_sync.sv
module adc_i2c_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  // idle bus lines are high, so reset to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '1;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/adc_i2c_ctrl.sv
module adc_i2c_ctrl
  import adc_i2c_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int RESULT_BYTES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclS,
  input  logic   sdaS,
  input  logic   addrMatch,
  input  logic   rwBit,
  input  logic   txBit,
  output dpCmd_t cmd,
  output logic   sdaPullLow
);

  localparam int CNT_W      = $clog2(BYTE_W + 1);
  localparam int BYTE_CNT_W = (RESULT_BYTES > 1) ? $clog2(RESULT_BYTES) : 1;
  localparam logic [CNT_W-1:0]      ADDR_BITS = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]      LAST_BIT  = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_CNT_W-1:0] LAST_BYTE = BYTE_CNT_W'(RESULT_BYTES - 1);

  slvState_t stateQ, stateD;
  logic [CNT_W-1:0]      bitCntQ, bitCntD;
  logic [BYTE_CNT_W-1:0] byteCntQ, byteCntD;
  logic                  masterAckQ, masterAckD;
  logic                  sclPrevQ, sdaPrevQ;
  logic                  sclRise, sclFall, startDet, stopDet;

  // edge and bus-condition detection on synchronised lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrevQ <= 1'b1;
      sdaPrevQ <= 1'b1;
    end else begin
      sclPrevQ <= sclS;
      sdaPrevQ <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrevQ;
  assign sclFall  = ~sclS & sclPrevQ;
  assign startDet = sclS & sclPrevQ & sdaPrevQ & ~sdaS;
  assign stopDet  = sclS & sclPrevQ & ~sdaPrevQ & sdaS;

  always_comb begin
    stateD     = stateQ;
    bitCntD    = bitCntQ;
    byteCntD   = byteCntQ;
    masterAckD = masterAckQ;
    cmd        = '0;

    if (stopDet) begin
      stateD = ST_IDLE;
    end else if (startDet) begin
      stateD   = ST_ADDR;
      bitCntD  = '0;
      byteCntD = '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sclRise && bitCntQ != ADDR_BITS) begin
            cmd.addrShift = 1'b1;
            bitCntD       = bitCntQ + 1'b1;
          end else if (sclFall && bitCntQ == ADDR_BITS) begin
            if (addrMatch && rwBit) begin
              stateD         = ST_ADDR_ACK;
              cmd.loadResult = 1'b1;
            end else begin
              stateD = ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            stateD   = ST_DATA;
            bitCntD  = '0;
            byteCntD = '0;
          end
        end
        ST_DATA: begin
          if (sclFall) begin
            cmd.dataShift = 1'b1;
            if (bitCntQ == LAST_BIT) begin
              bitCntD = '0;
              stateD  = (byteCntQ == LAST_BYTE) ? ST_WAIT : ST_DATA_ACK;
            end else begin
              bitCntD = bitCntQ + 1'b1;
            end
          end
        end
        ST_DATA_ACK: begin
          if (sclRise) begin
            masterAckD = ~sdaS;
          end else if (sclFall) begin
            if (masterAckQ) begin
              stateD   = ST_DATA;
              bitCntD  = '0;
              byteCntD = byteCntQ + 1'b1;
            end else begin
              stateD = ST_WAIT;
            end
          end
        end
        ST_WAIT: ;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      bitCntQ    <= '0;
      byteCntQ   <= '0;
      masterAckQ <= 1'b0;
    end else begin
      stateQ     <= stateD;
      bitCntQ    <= bitCntD;
      byteCntQ   <= byteCntD;
      masterAckQ <= masterAckD;
    end
  end

  // open-drain: only ever pull low or release
  assign sdaPullLow = (stateQ == ST_ADDR_ACK) | ((stateQ == ST_DATA) & ~txBit);

  AST_ACK_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ADDR_ACK && $past(stateQ) != ST_ADDR_ACK) |-> $past(addrMatch && rwBit)); // R1

  AST_REJECT_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_ADDR && stateQ == ST_WAIT) |-> !$past(addrMatch && rwBit)); // R2

  AST_LAST_BYTE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DATA && sclFall && !stopDet && !startDet && bitCntQ == LAST_BIT && byteCntQ == LAST_BYTE)
      |=> (stateQ == ST_WAIT)); // R5

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (stateQ == ST_ADDR && bitCntQ == '0)); // R7

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (stateQ == ST_IDLE && !sdaPullLow)); // R7

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS); // R8

endmodule

// File: rtl/adc_i2c_datapath.sv
module adc_i2c_datapath
  import adc_i2c_pkg::*;
#(
  parameter int          RESULT_W  = 16,
  parameter int          ADDR_W    = 7,
  parameter logic [6:0]  ADDR_LOW  = 7'b0010100,
  parameter logic [6:0]  ADDR_HIGH = 7'b1010100
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic                sdaS,
  input  logic                addrSel,
  input  logic [RESULT_W-1:0] resultData,
  input  logic                resultValid,
  output logic                addrMatch,
  output logic                rwBit,
  output logic                txBit
);

  logic [RESULT_W-1:0] holdQ;
  logic [RESULT_W-1:0] shiftQ;
  logic [ADDR_W:0]     addrQ;
  logic [ADDR_W-1:0]   ownAddr;

  // newest completed result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdQ <= '0;
    else if (resultValid) holdQ <= resultData;
  end

  // transmit shifter, MSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftQ <= '0;
    else if (cmd.loadResult) shiftQ <= resultValid ? resultData : holdQ;
    else if (cmd.dataShift)  shiftQ <= {shiftQ[RESULT_W-2:0], 1'b1};
  end

  // address plus R/W collector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrQ <= '0;
    else if (cmd.addrShift) addrQ <= {addrQ[ADDR_W-1:0], sdaS};
  end

  assign ownAddr   = addrSel ? ADDR_HIGH[ADDR_W-1:0] : ADDR_LOW[ADDR_W-1:0];
  assign addrMatch = (addrQ[ADDR_W:1] == ownAddr);
  assign rwBit     = addrQ[0];
  assign txBit     = shiftQ[RESULT_W-1];

  AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.loadResult || cmd.dataShift) |=> $stable(shiftQ)); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.addrShift, cmd.loadResult, cmd.dataShift})); // R3

endmodule

// File: rtl/adc_result_i2c_slave.sv
module adc_result_i2c_slave
  import adc_i2c_pkg::*;
#(
  parameter int         RESULT_W    = 16,
  parameter int         BYTE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LOW    = 7'b0010100,
  parameter logic [6:0] ADDR_HIGH   = 7'b1010100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaPullLow,
  input  logic                addrSel,
  input  logic [RESULT_W-1:0] resultData,
  input  logic                resultValid
);

  localparam int RESULT_BYTES = RESULT_W / BYTE_W;

  logic [1:0] busSync;
  logic       sclS, sdaS;
  logic       addrMatch, rwBit, txBit;
  dpCmd_t     cmd;

  adc_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({sclIn, sdaIn}), .syncOut(busSync)
  );

  assign sclS = busSync[1];
  assign sdaS = busSync[0];

  adc_i2c_ctrl #(.BYTE_W(BYTE_W), .RESULT_BYTES(RESULT_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .cmd(cmd), .sdaPullLow(sdaPullLow)
  );

  adc_i2c_datapath #(
    .RESULT_W(RESULT_W), .ADDR_W(7), .ADDR_LOW(ADDR_LOW), .ADDR_HIGH(ADDR_HIGH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaS(sdaS), .addrSel(addrSel),
    .resultData(resultData), .resultValid(resultValid),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit)
  );

endmodule

// File: tb/adc_result_i2c_slave_bench.sv
module adc_result_i2c_slave_bench;

  localparam int Q = 20;  // system clocks per quarter bit

  logic        clk = 1'b0, rstN = 1'b0;
  logic        sclM = 1'b1, sdaM = 1'b1;
  logic        addrSel = 1'b0, resultValid = 1'b0;
  logic [15:0] resultData = '0;
  logic        sdaPullLow, sdaBus;

  int checks = 0, errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] obsByte;
  event       obsEv;

  always #5 clk = ~clk;

  assign sdaBus = sdaM & ~sdaPullLow;

  adc_result_i2c_slave u_adc_result_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow),
    .addrSel(addrSel), .resultData(resultData), .resultValid(resultValid)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input logic b, output logic r);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ();
    r = sdaBus; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic restartCond();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendAddr(input logic [6:0] a, input logic rw, output logic acked);
    logic r;
    for (int i = 6; i >= 0; i--) bitCycle(a[i], r);
    bitCycle(rw, r);
    bitCycle(1'b1, r);
    acked = ~r;
  endtask

  task automatic readByte(input logic masterAck);
    logic r;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, r);
      v[i] = r;
    end
    obsByte = v;
    ->obsEv;
    bitCycle(~masterAck, r);
  endtask

  task automatic expectByte(input logic [7:0] b, input string tag);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  task automatic postResult(input logic [15:0] v);
    @(negedge clk); resultData = v; resultValid = 1'b1;
    @(negedge clk); resultValid = 1'b0;
  endtask

  // monitor: compare each byte the master collects with the scoreboard
  initial begin
    forever begin
      @(obsEv);
      if (expQ.size() == 0) begin
        chk(1'b0, "R3", "unexpected byte", int'(obsByte), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(obsByte == e, t, "read byte", int'(obsByte), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic r;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdaPullLow == 1'b0, "R8", "reset pull", int'(sdaPullLow), 0);

    // strap low, zero-input code
    addrSel = 1'b0;
    postResult(16'h8000);
    startCond();
    sendAddr(7'b0010100, 1'b1, ack);
    chk(ack == 1'b1, "R1", "ack strap low", int'(ack), 1);
    expectByte(8'h80, "R3"); expectByte(8'h00, "R3");
    readByte(1'b1); readByte(1'b0);
    stopCond();

    // other address with strap low: ignored
    startCond();
    sendAddr(7'b1010100, 1'b1, ack);
    chk(ack == 1'b0, "R1", "no ack wrong addr", int'(ack), 0);
    expectByte(8'hFF, "R2");
    readByte(1'b0);
    stopCond();

    // strap high, 8 LSB below zero, then read past end
    addrSel = 1'b1;
    postResult(16'h7FF8);
    startCond();
    sendAddr(7'b1010100, 1'b1, ack);
    chk(ack == 1'b1, "R1", "ack strap high", int'(ack), 1);
    expectByte(8'h7F, "R3"); expectByte(8'hF8, "R3"); expectByte(8'hFF, "R5");
    readByte(1'b1); readByte(1'b1); readByte(1'b0);
    stopCond();
    repeat (8) @(negedge clk);
    chk(sdaPullLow == 1'b0 && sdaBus == 1'b1, "R7", "released after stop", int'(sdaPullLow), 0);

    // write request is refused
    startCond();
    sendAddr(7'b1010100, 1'b0, ack);
    chk(ack == 1'b0, "R2", "no ack on write", int'(ack), 0);
    expectByte(8'hFF, "R2");
    readByte(1'b0);
    stopCond();

    // master NACK after first byte, then repeated START
    postResult(16'h1234);
    startCond();
    sendAddr(7'b1010100, 1'b1, ack);
    chk(ack == 1'b1, "R4", "ack before nack test", int'(ack), 1);
    expectByte(8'h12, "R4"); expectByte(8'hFF, "R4");
    readByte(1'b0); readByte(1'b0);
    restartCond();
    sendAddr(7'b1010100, 1'b1, ack);
    chk(ack == 1'b1, "R7", "ack after repeated start", int'(ack), 1);
    expectByte(8'h12, "R7"); expectByte(8'h34, "R7");
    readByte(1'b1); readByte(1'b0);
    stopCond();

    // repeated START in the middle of the address
    startCond();
    bitCycle(1'b0, r); bitCycle(1'b1, r); bitCycle(1'b1, r);
    restartCond();
    sendAddr(7'b1010100, 1'b1, ack);
    chk(ack == 1'b1, "R7", "ack after address restart", int'(ack), 1);
    expectByte(8'h12, "R7"); expectByte(8'h34, "R7");
    readByte(1'b1); readByte(1'b0);
    stopCond();

    // new result during transfer is held for the next read
    postResult(16'hA5C3);
    startCond();
    sendAddr(7'b1010100, 1'b1, ack);
    chk(ack == 1'b1, "R6", "ack capture test", int'(ack), 1);
    postResult(16'h5A3C);
    expectByte(8'hA5, "R6"); expectByte(8'hC3, "R6");
    readByte(1'b1); readByte(1'b0);
    stopCond();
    startCond();
    sendAddr(7'b1010100, 1'b1, ack);
    chk(ack == 1'b1, "R6", "ack second capture", int'(ack), 1);
    expectByte(8'h5A, "R6"); expectByte(8'h3C, "R6");
    readByte(1'b1); readByte(1'b0);
    stopCond();

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R3", "scoreboard drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule